// File: doc/BRIEF.md
# Receive Descriptor Ring Engine

This engine places incoming Ethernet frames into host memory through a ring of receive descriptors. Frames arrive one byte per beat on a valid/ready stream with an end-of-frame marker. When a frame starts, the engine probes descriptors one after another, beginning at its current ring index. It takes the first descriptor whose flag byte shows that the controller owns it and that no other flag is set. It then streams the frame into that descriptor's buffer as 16-bit little-endian words and pads short frames with zero bytes. It writes the stored byte count into the descriptor and returns ownership to the host by rewriting the flag byte.

A one-cycle done strobe tells the status register that a frame has landed. A one-cycle miss strobe reports a frame that found no usable descriptor. A halt input, driven from the controller's stop state, makes the engine discard frames. While the engine is idle it sweeps the ring flag words in the background, so a level output can tell the receive path whether any descriptor is free. CRC checking, address filtering and memory arbitration are left to neighbouring blocks. The memory port returns read data in the same cycle it is addressed.

Each descriptor takes four consecutive 16-bit words starting at `DESC_BASE + 4*index`:
- word 0 holds the low 16 bits of the buffer byte address;
- word 1 holds the flag byte in bits 15:8 and the high address byte in bits 7:0;
- word 2 holds the buffer length as a negative two's-complement value, which the engine never touches;
- word 3 receives the stored byte count.

Flag bits in the flag byte:
- OWN = 0x80
- ERR = 0x40
- FRA = 0x20
- OFL = 0x10
- CRC = 0x08
- BUF = 0x04
- SOP = 0x02
- EOP = 0x01

Top module: `rx_ring_engine`

## Requirements
- R1: After reset, `s_ready`, `ring_avail`, `rx_done_stb` and `rx_miss_stb` are low, and the ring index is 0, so the first frame searches from descriptor 0.
- R2: A descriptor is usable only when its flag byte (word 1, bits 15:8) equals exactly 0x80. Any other value, including 0x80 combined with another flag bit, is skipped and left unmodified.
- R3: The search starts at the ring index and ascends modulo the ring size (2^RING_LOG). The first usable descriptor reached is the one filled.
- R4: Frame byte j is stored at word `((({high byte, low word}) >> 1) mod 2^AW) + j/2`, in bits 7:0 when j is even and bits 15:8 when j is odd. A frame that ends on an even byte position stores zero in the upper half of its last word.
- R5: A frame shorter than MIN_LEN bytes is padded with zero bytes up to MIN_LEN, and the stored count is MIN_LEN.
- R6: Bytes beyond BUF_BYTES are consumed but not stored, and the stored count is BUF_BYTES. No buffer word beyond the stored count is written.
- R7: After the data, word 3 receives the stored count and word 1 becomes {0x03, high address byte}, which clears OWN and sets SOP and EOP. Words 0 and 2 keep their values.
- R8: Each stored frame produces exactly one single-cycle `rx_done_stb`, and the ring index becomes the used index plus one, modulo the ring size.
- R9: If every descriptor is unusable, the frame is fully consumed and discarded. Memory is not written, one single-cycle `rx_miss_stb` is produced, and the ring index is unchanged.
- R10: While `rx_halt` is high, frames are consumed and discarded with no memory write and no strobe, and `ring_avail` is low.
- R11: With the engine idle and `rx_halt` low, `ring_avail` reflects within 2^RING_LOG + 2 cycles whether any descriptor is usable.
- R12: `rx_done_stb` and `rx_miss_stb` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_halt | input | 1 | Controller stopped: discard frames |
| s_valid | input | 1 | Frame byte valid |
| s_data | input | 8 | Frame byte |
| s_last | input | 1 | Last byte of frame |
| s_ready | output | 1 | Byte accepted when high with s_valid |
| mem_addr | output | AW | Memory word address |
| mem_rdata | input | 16 | Read data for mem_addr, same cycle |
| mem_we | output | 1 | Memory write enable |
| mem_wdata | output | 16 | Memory write data |
| ring_avail | output | 1 | Some descriptor is usable |
| rx_done_stb | output | 1 | One-cycle frame-stored strobe |
| rx_miss_stb | output | 1 | One-cycle frame-missed strobe |

## Verification
The bench builds the engine with a four-entry ring (RING_LOG=2), 16-byte buffers, a 6-byte minimum and an 8-bit word address. With these values, index wrap, padding, truncation and address wrap all occur with frames of at most 20 bytes. It sweeps every frame length from 1 to 20, so odd, even, padded and truncated frames each land in rotating descriptors, and it checks every buffer word against a computed byte pattern. Further runs place non-exact flag values before a usable descriptor, empty the whole ring and halt the engine. Each of these runs checks the index that the following frame uses.

// File: rtl/rxr_pkg.sv
package rxr_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SEARCH,
        ST_GETA,
        ST_COPY,
        ST_PAD,
        ST_LENW,
        ST_FLAGW,
        ST_DROP
    } rxr_state_e;

    typedef enum logic [1:0] {
        W_ADDR_LO = 2'd0,
        W_FLAGS   = 2'd1,
        W_BUFLEN  = 2'd2,
        W_MSGLEN  = 2'd3
    } desc_word_e;

    typedef struct packed {
        logic [7:0] flags;
        logic [7:0] hi_addr;
    } flag_word_t;

    localparam logic [7:0] FLG_OWN  = 8'h80;
    localparam logic [7:0] FLG_ERR  = 8'h40;
    localparam logic [7:0] FLG_FRA  = 8'h20;
    localparam logic [7:0] FLG_OFL  = 8'h10;
    localparam logic [7:0] FLG_CRC  = 8'h08;
    localparam logic [7:0] FLG_BUF  = 8'h04;
    localparam logic [7:0] FLG_SOP  = 8'h02;
    localparam logic [7:0] FLG_EOP  = 8'h01;
    localparam logic [7:0] FLG_DONE = FLG_SOP | FLG_EOP;

    function automatic logic flags_usable(input logic [7:0] f);
        return f == FLG_OWN;
    endfunction

endpackage

// File: rtl/rxr_own_map.sv
module rxr_own_map
    import rxr_pkg::*;
#(
    parameter int RING_LOG = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                halt,
    input  logic                obs_en,
    input  logic                poll_adv,
    input  logic [RING_LOG-1:0] obs_idx,
    input  logic [7:0]          obs_flags,
    input  logic                clr_en,
    input  logic [RING_LOG-1:0] clr_idx,
    output logic [RING_LOG-1:0] poll_idx,
    output logic                avail
);
    localparam int RING = 1 << RING_LOG;

    logic [RING-1:0]     map_q;
    logic [RING_LOG-1:0] poll_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            map_q  <= '0;
            poll_q <= '0;
        end else begin
            if (poll_adv)
                poll_q <= poll_q + 1'b1;
            if (obs_en)
                map_q[obs_idx] <= flags_usable(obs_flags);
            if (clr_en)
                map_q[clr_idx] <= 1'b0;
        end
    end

    assign poll_idx = poll_q;
    assign avail    = (|map_q) && !halt;

    // R11: a descriptor handed back to the host no longer counts as free
    p_clr_drops_r11: assert property (@(posedge clk) disable iff (rst)
        clr_en |=> !map_q[$past(clr_idx)]);

endmodule

// File: rtl/rxr_pack.sv
module rxr_pack
    import rxr_pkg::*;
#(
    parameter int BUF_BYTES = 1544,
    parameter int CW        = 11
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          take,
    input  logic [7:0]    data,
    input  logic          last,
    input  logic          pad,
    output logic          wr_en,
    output logic [CW-1:0] wr_off,
    output logic [15:0]   wr_data,
    output logic [CW-1:0] cnt
);
    localparam logic [CW-1:0] BUF_C = CW'(BUF_BYTES);

    logic [CW-1:0] cnt_q;
    logic [7:0]    lo_q;
    logic          room;

    assign room = cnt_q < BUF_C;

    always_comb begin
        wr_en   = 1'b0;
        wr_off  = cnt_q >> 1;
        wr_data = 16'h0000;
        if (take && room) begin
            if (cnt_q[0]) begin
                wr_en   = 1'b1;
                wr_data = {data, lo_q};
            end else if (last) begin
                wr_en   = 1'b1;
                wr_data = {8'h00, data};
            end
        end else if (pad && !cnt_q[0]) begin
            wr_en = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt_q <= '0;
            lo_q  <= '0;
        end else if (take && room) begin
            cnt_q <= cnt_q + CW'(1);
            if (!cnt_q[0])
                lo_q <= data;
        end else if (pad) begin
            cnt_q <= cnt_q + (cnt_q[0] ? CW'(1) : CW'(2));
        end
    end

    assign cnt = cnt_q;

    // R6: stored count never passes the buffer size
    p_cnt_bound_r6: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= BUF_C);

    // R6: no word beyond the buffer is written
    p_off_bound_r6: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (32'(wr_off) < BUF_BYTES / 2));

endmodule

// File: rtl/rx_ring_engine.sv
module rx_ring_engine
    import rxr_pkg::*;
#(
    parameter int RING_LOG  = 4,
    parameter int BUF_BYTES = 1544,
    parameter int MIN_LEN   = 60,
    parameter int AW        = 16,
    parameter int DESC_BASE = 0
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          rx_halt,
    input  logic          s_valid,
    input  logic [7:0]    s_data,
    input  logic          s_last,
    output logic          s_ready,
    output logic [AW-1:0] mem_addr,
    input  logic [15:0]   mem_rdata,
    output logic          mem_we,
    output logic [15:0]   mem_wdata,
    output logic          ring_avail,
    output logic          rx_done_stb,
    output logic          rx_miss_stb
);
    localparam int RING = 1 << RING_LOG;
    localparam int CW   = $clog2(BUF_BYTES + 1);
    localparam logic [CW-1:0]       MIN_C      = CW'(MIN_LEN);
    localparam logic [RING_LOG-1:0] LAST_PROBE = RING_LOG'(RING - 1);

    rxr_state_e          state_q;
    logic [RING_LOG-1:0] idx_q, ptr_q, probes_q, poll_idx;
    logic [7:0]          hadr_q;
    logic [AW-1:0]       base_q;
    logic                done_q, miss_q;
    flag_word_t          rd_fw;

    logic                pk_we;
    logic [CW-1:0]       pk_off, pk_cnt;
    logic [15:0]         pk_data;
    logic                pk_take, pk_pad;

    function automatic logic [AW-1:0] dword(input logic [RING_LOG-1:0] i,
                                            input desc_word_e w);
        return AW'(DESC_BASE) + AW'({i, w});
    endfunction

    assign rd_fw   = flag_word_t'(mem_rdata);
    assign s_ready = (state_q == ST_COPY) || (state_q == ST_DROP);
    assign pk_take = (state_q == ST_COPY) && s_valid;
    assign pk_pad  = (state_q == ST_PAD) && (pk_cnt < MIN_C);

    rxr_own_map #(.RING_LOG(RING_LOG)) u_map (
        .clk       (clk),
        .rst       (rst),
        .halt      (rx_halt),
        .obs_en    ((state_q == ST_IDLE) || (state_q == ST_SEARCH)),
        .poll_adv  (state_q == ST_IDLE),
        .obs_idx   ((state_q == ST_IDLE) ? poll_idx : ptr_q),
        .obs_flags (rd_fw.flags),
        .clr_en    (state_q == ST_FLAGW),
        .clr_idx   (ptr_q),
        .poll_idx  (poll_idx),
        .avail     (ring_avail)
    );

    rxr_pack #(.BUF_BYTES(BUF_BYTES), .CW(CW)) u_pack (
        .clk     (clk),
        .rst     (rst),
        .clr     (state_q == ST_GETA),
        .take    (pk_take),
        .data    (s_data),
        .last    (s_last),
        .pad     (pk_pad),
        .wr_en   (pk_we),
        .wr_off  (pk_off),
        .wr_data (pk_data),
        .cnt     (pk_cnt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            idx_q    <= '0;
            ptr_q    <= '0;
            probes_q <= '0;
            hadr_q   <= '0;
            base_q   <= '0;
            done_q   <= 1'b0;
            miss_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            miss_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (s_valid) begin
                        if (rx_halt) begin
                            state_q <= ST_DROP;
                        end else begin
                            state_q  <= ST_SEARCH;
                            ptr_q    <= idx_q;
                            probes_q <= '0;
                        end
                    end
                end
                ST_SEARCH: begin
                    if (flags_usable(rd_fw.flags)) begin
                        hadr_q  <= rd_fw.hi_addr;
                        state_q <= ST_GETA;
                    end else if (probes_q == LAST_PROBE) begin
                        miss_q  <= 1'b1;
                        state_q <= ST_DROP;
                    end else begin
                        ptr_q    <= ptr_q + 1'b1;
                        probes_q <= probes_q + 1'b1;
                    end
                end
                ST_GETA: begin
                    base_q  <= AW'({hadr_q, mem_rdata} >> 1);
                    state_q <= ST_COPY;
                end
                ST_COPY: begin
                    if (s_valid && s_last)
                        state_q <= ST_PAD;
                end
                ST_PAD: begin
                    if (!(pk_cnt < MIN_C))
                        state_q <= ST_LENW;
                end
                ST_LENW: begin
                    state_q <= ST_FLAGW;
                end
                ST_FLAGW: begin
                    done_q  <= 1'b1;
                    idx_q   <= ptr_q + 1'b1;
                    state_q <= ST_IDLE;
                end
                ST_DROP: begin
                    if (s_valid && s_last)
                        state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        mem_addr  = dword(poll_idx, W_FLAGS);
        mem_we    = 1'b0;
        mem_wdata = 16'h0000;
        unique case (state_q)
            ST_SEARCH: mem_addr = dword(ptr_q, W_FLAGS);
            ST_GETA:   mem_addr = dword(ptr_q, W_ADDR_LO);
            ST_COPY, ST_PAD: begin
                mem_addr  = base_q + AW'(pk_off);
                mem_we    = pk_we;
                mem_wdata = pk_data;
            end
            ST_LENW: begin
                mem_addr  = dword(ptr_q, W_MSGLEN);
                mem_we    = 1'b1;
                mem_wdata = 16'(pk_cnt);
            end
            ST_FLAGW: begin
                mem_addr  = dword(ptr_q, W_FLAGS);
                mem_we    = 1'b1;
                mem_wdata = {FLG_DONE, hadr_q};
            end
            default: ;
        endcase
    end

    assign rx_done_stb = done_q;
    assign rx_miss_stb = miss_q;

    // R12: never both strobes at once
    p_one_strobe_r12: assert property (@(posedge clk) disable iff (rst)
        !(rx_done_stb && rx_miss_stb));

    // R8: index steps past the used descriptor
    p_idx_step_r8: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_FLAGW) |=> (idx_q == $past(ptr_q) + 1'b1));

    // R2: a descriptor is taken only after its flag byte read exactly OWN
    p_hit_exact_r2: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_SEARCH) && (rd_fw.flags != FLG_OWN) |=> (state_q != ST_GETA));

    // R9: a missed frame leaves memory alone
    p_miss_nowrite_r9: assert property (@(posedge clk) disable iff (rst)
        rx_miss_stb |-> !mem_we);

    // R10: discarded bytes never reach memory
    p_drop_nowrite_r10: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_DROP) |-> !mem_we);

    // R10: halt hides free descriptors
    p_halt_avail_r10: assert property (@(posedge clk) disable iff (rst)
        rx_halt |-> !ring_avail);

endmodule

// File: tb/rx_ring_engine_bench.sv
module rx_ring_engine_bench;
    localparam int RL   = 2;
    localparam int RING = 1 << RL;
    localparam int BUFB = 16;
    localparam int MINL = 6;
    localparam int AW   = 8;
    localparam int MEMW = 1 << AW;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic rx_halt = 1'b0;
    logic s_valid = 1'b0;
    logic [7:0] s_data = 8'h00;
    logic s_last = 1'b0;
    logic s_ready;
    logic [AW-1:0] mem_addr;
    logic [15:0] mem_rdata;
    logic mem_we;
    logic [15:0] mem_wdata;
    logic ring_avail, rx_done_stb, rx_miss_stb;

    logic [15:0] mem [0:MEMW-1];
    logic [15:0] snap [0:MEMW-1];
    logic host_we = 1'b0;
    logic [AW-1:0] host_addr = '0;
    logic [15:0] host_data = '0;

    int tests = 0;
    int fails = 0;
    int done_cnt = 0;
    int miss_cnt = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    rx_ring_engine #(
        .RING_LOG(RL), .BUF_BYTES(BUFB), .MIN_LEN(MINL), .AW(AW), .DESC_BASE(0)
    ) u_rx_ring_engine (
        .clk(clk), .rst(rst), .rx_halt(rx_halt),
        .s_valid(s_valid), .s_data(s_data), .s_last(s_last), .s_ready(s_ready),
        .mem_addr(mem_addr), .mem_rdata(mem_rdata), .mem_we(mem_we),
        .mem_wdata(mem_wdata), .ring_avail(ring_avail),
        .rx_done_stb(rx_done_stb), .rx_miss_stb(rx_miss_stb)
    );

    assign mem_rdata = mem[mem_addr];

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < MEMW; i++) mem[i] <= 16'h0000;
        end else if (mem_we) begin
            mem[mem_addr] <= mem_wdata;
        end else if (host_we) begin
            mem[host_addr] <= host_data;
        end
        if (!rst) begin
            if (rx_done_stb) done_cnt <= done_cnt + 1;
            if (rx_miss_stb) miss_cnt <= miss_cnt + 1;
        end
    end

    function automatic logic [7:0] pat(input int seed, input int j);
        return 8'(seed * 37 + j * 11 + 5);
    endfunction
    function automatic logic [7:0] hadr(input int d);
        return 8'(8'h50 + d);
    endfunction
    function automatic logic [15:0] lowa(input int d);
        return 16'(64 + 16 * d);
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic host_write(input int a, input logic [15:0] v);
        @(negedge clk);
        host_we = 1'b1; host_addr = AW'(a); host_data = v;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic set_flags(input int d, input logic [7:0] f);
        host_write(4 * d + 1, {f, hadr(d)});
    endtask

    task automatic arm(input int d, input logic [7:0] f);
        host_write(4 * d, lowa(d));
        set_flags(d, f);
        host_write(4 * d + 2, 16'hFFF0);
        host_write(4 * d + 3, 16'h0000);
        for (int w = 0; w < BUFB / 2; w++) host_write(32 + 8 * d + w, 16'hDEAD);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_frame(input int len, input int seed);
        for (int k = 0; k < len; k++) begin
            @(negedge clk);
            s_valid = 1'b1; s_data = pat(seed, k); s_last = (k == len - 1);
            while (!s_ready) @(negedge clk);
            @(posedge clk);
        end
        @(negedge clk);
        s_valid = 1'b0; s_last = 1'b0;
        idle(12);
    endtask

    task automatic take_snap();
        for (int i = 0; i < MEMW; i++) snap[i] = mem[i];
    endtask

    function automatic int snap_diffs();
        int n = 0;
        for (int i = 0; i < MEMW; i++) if (snap[i] !== mem[i]) n++;
        return n;
    endfunction

    task automatic check_frame(input int d, input int len, input int seed);
        int c;
        int bad;
        int first_act;
        int first_exp;
        logic [7:0] lo;
        logic [7:0] hi;
        c = (len > BUFB) ? BUFB : ((len < MINL) ? MINL : len);
        chk(mem[4 * d + 3] == 16'(c), "R5/R6/R7 stored count", int'(mem[4 * d + 3]), c);
        chk(mem[4 * d + 1] == {8'h03, hadr(d)}, "R7 flag word", int'(mem[4 * d + 1]),
            int'({8'h03, hadr(d)}));
        chk(mem[4 * d] == lowa(d) && mem[4 * d + 2] == 16'hFFF0, "R7 words 0/2 kept",
            int'(mem[4 * d + 2]), 16'hFFF0);
        bad = 0; first_act = 0; first_exp = 0;
        for (int w = 0; w < (c + 1) / 2; w++) begin
            lo = (2 * w < len) ? pat(seed, 2 * w) : 8'h00;
            hi = (2 * w + 1 < len) ? pat(seed, 2 * w + 1) : 8'h00;
            if (mem[32 + 8 * d + w] !== {hi, lo}) begin
                if (bad == 0) begin
                    first_act = int'(mem[32 + 8 * d + w]);
                    first_exp = int'({hi, lo});
                end
                bad++;
            end
        end
        chk(bad == 0, "R4/R5 buffer data", first_act, first_exp);
        if ((c + 1) / 2 < BUFB / 2)
            chk(mem[32 + 8 * d + (c + 1) / 2] == 16'hDEAD, "R6 word past count untouched",
                int'(mem[32 + 8 * d + (c + 1) / 2]), 16'hDEAD);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            fails++;
            tests++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        int m;
        int d0;
        int dc;
        m = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        chk(s_ready == 1'b0, "R1 s_ready after reset", int'(s_ready), 0);
        chk(rx_done_stb == 1'b0 && rx_miss_stb == 1'b0, "R1 strobes after reset",
            int'({rx_done_stb, rx_miss_stb}), 0);
        chk(ring_avail == 1'b0, "R1 ring_avail after reset", int'(ring_avail), 0);
        idle(RING + 4);
        chk(ring_avail == 1'b0, "R11 empty ring not available", int'(ring_avail), 0);

        for (int d = 0; d < RING; d++) arm(d, 8'h80);
        idle(RING + 4);
        chk(ring_avail == 1'b1, "R11 armed ring available", int'(ring_avail), 1);

        // Length sweep: R1 (first lands at 0), R3, R4, R5, R6, R7, R8
        for (int len = 1; len <= 20; len++) begin
            dc = done_cnt;
            d0 = miss_cnt;
            send_frame(len, len);
            check_frame(m, len, len);
            chk(done_cnt == dc + 1, "R8 one done strobe", done_cnt - dc, 1);
            chk(miss_cnt == d0, "R12 no miss on stored frame", miss_cnt - d0, 0);
            arm(m, 8'h80);
            m = (m + 1) % RING;
        end

        // R2/R3: inexact flags skipped, m is 0 here
        set_flags(0, 8'h81);
        set_flags(1, 8'h00);
        set_flags(2, 8'hC0);
        send_frame(8, 99);
        check_frame(3, 8, 99);
        chk(mem[1] == {8'h81, hadr(0)}, "R2 flag 0x81 skipped", int'(mem[1]),
            int'({8'h81, hadr(0)}));
        chk(mem[9] == {8'hC0, hadr(2)}, "R2 flag 0xC0 skipped", int'(mem[9]),
            int'({8'hC0, hadr(2)}));
        // R8 wrap to 0: only 0 and 1 usable, index 0 picks 0
        arm(0, 8'h80); arm(1, 8'h80); arm(3, 8'h00);
        send_frame(7, 55);
        check_frame(0, 7, 55);
        // index now 1; only desc 0 usable -> search 1,2,3,0 (R3 wrap)
        set_flags(1, 8'h00);
        arm(0, 8'h80);
        send_frame(9, 77);
        check_frame(0, 9, 77);

        // R9 miss: index is 1
        for (int d = 0; d < RING; d++) set_flags(d, 8'h00);
        idle(RING + 4);
        chk(ring_avail == 1'b0, "R11 none usable", int'(ring_avail), 1'b0);
        take_snap();
        dc = done_cnt; d0 = miss_cnt;
        send_frame(10, 3);
        chk(miss_cnt == d0 + 1, "R9 one miss strobe", miss_cnt - d0, 1);
        chk(done_cnt == dc, "R9 no done strobe", done_cnt - dc, 0);
        chk(snap_diffs() == 0, "R9 memory unchanged", snap_diffs(), 0);
        arm(1, 8'h80); arm(2, 8'h80);
        send_frame(6, 4);
        check_frame(1, 6, 4);  // R9 index unchanged at 1

        // R10 halt
        arm(0, 8'h80); arm(1, 8'h80); arm(3, 8'h80);
        @(negedge clk); rx_halt = 1'b1;
        idle(RING + 4);
        chk(ring_avail == 1'b0, "R10 halt hides ring", int'(ring_avail), 0);
        take_snap();
        dc = done_cnt; d0 = miss_cnt;
        send_frame(12, 8);
        chk(snap_diffs() == 0, "R10 memory unchanged", snap_diffs(), 0);
        chk(done_cnt == dc && miss_cnt == d0, "R10 no strobes",
            done_cnt - dc + miss_cnt - d0, 0);
        @(negedge clk); rx_halt = 1'b0;
        idle(RING + 4);
        chk(ring_avail == 1'b1, "R11 available after halt", int'(ring_avail), 1);
        send_frame(11, 12);
        check_frame(2, 11, 12);

        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule